// File: doc/BRIEF.md
# Paired CORDIC Givens Rotator

This block performs one real-valued Givens rotation per operand set using two fixed-point CORDIC engines that advance side by side. The leading engine works in vectoring mode. It turns its input pair (x, y) until y is driven to zero, and its x output then holds the length of the original vector. At each micro-rotation it decides a direction from the sign of its own y. The trailing engine uses those same direction decisions to turn a second pair through the identical angle. No angle value is formed or stored anywhere in the datapath.

Each pipeline stage completes two shift-and-add micro-rotations. Eight iterations therefore take four stages. A fifth stage multiplies both pairs by the reciprocal of the accumulated CORDIC gain. When the leading x is negative, both pairs are first turned by half a revolution (both coordinates negated) so that the leading vector starts in the right half-plane. A new operand set may be presented on every clock. The block is intended as the rotation cell of a triangularisation array: the leading pair is the element being zeroed, and the trailing pair is any other column entry on the same two rows.

Inputs are signed 16-bit integers. Outputs are signed 17-bit integers, so a magnitude up to the square root of 2 times full scale fits. Internally the datapath carries 2 guard bits and 4 fraction bits.

Top module: `givens_cordic_pair`

## Requirements
- R1: While rst_n is low, and afterwards until the first operand set has travelled through the pipeline, valid_out is 0, whatever valid_in does during reset.
- R2: valid_out is high exactly when valid_in was high at the rising edge five clock edges earlier (latency of 5 cycles).
- R3: Operand sets presented on consecutive cycles produce results on consecutive cycles, in the same order, each free of unknown bits.
- R4: The leading x output is non-negative, and sqrt(lead_x_out^2 + lead_y_out^2) is within 4 LSB of sqrt(lead_x_in^2 + lead_y_in^2).
- R5: The leading y residual obeys |lead_y_out| <= lead_x_out/64 + 2, with /64 an arithmetic right shift by 6.
- R6: The trailing output is within 8 LSB per coordinate of the trailing input turned by the angle atan2(lead_y_out, lead_x_out) - atan2(lead_y_in, lead_x_in), which is the rotation the leading pair actually underwent.
- R7: A negative lead_x_in is handled by negating both pairs before the iterations, so leading vectors in the left half-plane also meet R4 to R6.
- R8: Full-scale inputs, including -32768 on both leading coordinates (magnitude 46341), do not overflow the internal or output widths.
- R9: A gapped valid_in pattern appears unchanged on valid_out, shifted by five cycles.
- R10: A zero leading pair yields a zero leading output (each coordinate within 1 LSB), and the trailing length is kept within 6 LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| valid_in | input | 1 | Operand set on the data inputs is to be rotated |
| lead_x_in | input | 16 | Leading pair x, signed |
| lead_y_in | input | 16 | Leading pair y, signed; the coordinate to be zeroed |
| trail_x_in | input | 16 | Trailing pair x, signed |
| trail_y_in | input | 16 | Trailing pair y, signed |
| valid_out | output | 1 | Result outputs hold a rotated operand set |
| lead_x_out | output | 17 | Length of the leading vector, signed, non-negative |
| lead_y_out | output | 17 | Leading y residual after rotation, signed |
| trail_x_out | output | 17 | Rotated trailing x, signed |
| trail_y_out | output | 17 | Rotated trailing y, signed |

## Verification
The checker assumes that valid_in is known at every rising edge once reset has lifted. The latency property compares against a history that begins only after five post-reset edges, so valid_in may take any value while reset is held. The residual and sign properties assume nothing about the data, because they hold for every 16-bit input, including the zero vector and the most negative value. The stimulus keeps every leading length used for the angle-consistency checks at 8000 or above, so that the quantisation of lead_y_out spoils the recovered angle by well under the 8 LSB allowance.

// File: rtl/gvr_pkg.sv
package gvr_pkg;

    localparam int DATA_W    = 16;
    localparam int GUARD_W   = 2;
    localparam int FRAC_W    = 4;
    localparam int ACC_W     = DATA_W + GUARD_W + FRAC_W;
    localparam int OUT_W     = DATA_W + 1;
    localparam int ITERS     = 8;
    localparam int PER_CLK   = 2;
    localparam int NSTAGE    = ITERS / PER_CLK;
    localparam int LATENCY   = NSTAGE + 1;
    localparam int GAIN_FRAC = 16;
    localparam int PROD_W    = ACC_W + GAIN_FRAC + 1;
    localparam int SCALE_SH  = GAIN_FRAC + FRAC_W;

    // product of 1/sqrt(1+2^-2i) over i = 0..7, scaled by 2^16; tied to ITERS = 8
    localparam logic signed [GAIN_FRAC:0] GAIN_Q = 17'sd39797;
    localparam logic signed [PROD_W-1:0] ROUND_HALF = PROD_W'(1) <<< (SCALE_SH - 1);

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t x;
        acc_t y;
    } pair_t;

    // sign-extend into the accumulator, place the fraction bits, optionally negate
    function automatic acc_t widen(input logic signed [DATA_W-1:0] v, input logic neg);
        acc_t w;
        w = acc_t'(v) <<< FRAC_W;
        return neg ? -w : w;
    endfunction

    // one shift-and-add step; dir = 1 turns clockwise
    function automatic pair_t micro_step(input pair_t p, input logic dir, input int unsigned sh);
        pair_t r;
        acc_t  px;
        acc_t  py;
        acc_t  xs;
        acc_t  ys;
        px = p.x;
        py = p.y;
        xs = px >>> sh;
        ys = py >>> sh;
        if (dir) begin
            r.x = px + ys;
            r.y = py - xs;
        end else begin
            r.x = px - ys;
            r.y = py + xs;
        end
        return r;
    endfunction

    // gain correction with round-to-nearest, back to integer output scale
    function automatic logic signed [OUT_W-1:0] descale(input acc_t v);
        logic signed [PROD_W-1:0] prod;
        prod = v * GAIN_Q;
        prod = prod + ROUND_HALF;
        return prod[SCALE_SH +: OUT_W];
    endfunction

endpackage

// File: rtl/gvr_stage.sv
module gvr_stage
    import gvr_pkg::*;
#(
    parameter int FIRST_ITER = 0
) (
    input  logic  clk,
    input  pair_t lead_i,
    input  pair_t trail_i,
    output pair_t lead_o,
    output pair_t trail_o
);

    pair_t lead_c  [PER_CLK+1];
    pair_t trail_c [PER_CLK+1];
    logic  dir     [PER_CLK];

    assign lead_c[0]  = lead_i;
    assign trail_c[0] = trail_i;

    for (genvar k = 0; k < PER_CLK; k++) begin : g_step
        // vectoring decision taken from the leading y only
        assign dir[k]         = ~lead_c[k].y[ACC_W-1];
        assign lead_c[k+1]    = micro_step(lead_c[k], dir[k], FIRST_ITER + k);
        // trailing engine reuses the direction bit, never an angle
        assign trail_c[k+1]   = micro_step(trail_c[k], dir[k], FIRST_ITER + k);
    end

    always_ff @(posedge clk) begin
        lead_o  <= lead_c[PER_CLK];
        trail_o <= trail_c[PER_CLK];
    end

endmodule

// File: rtl/gvr_gain.sv
module gvr_gain
    import gvr_pkg::*;
(
    input  logic                    clk,
    input  pair_t                   p_i,
    output logic signed [OUT_W-1:0] x_o,
    output logic signed [OUT_W-1:0] y_o
);

    always_ff @(posedge clk) begin
        x_o <= descale(p_i.x);
        y_o <= descale(p_i.y);
    end

endmodule

// File: rtl/givens_cordic_pair.sv
module givens_cordic_pair
    import gvr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_in,
    input  logic signed [DATA_W-1:0] lead_x_in,
    input  logic signed [DATA_W-1:0] lead_y_in,
    input  logic signed [DATA_W-1:0] trail_x_in,
    input  logic signed [DATA_W-1:0] trail_y_in,
    output logic                     valid_out,
    output logic signed [OUT_W-1:0]  lead_x_out,
    output logic signed [OUT_W-1:0]  lead_y_out,
    output logic signed [OUT_W-1:0]  trail_x_out,
    output logic signed [OUT_W-1:0]  trail_y_out
);

    logic               half_turn;
    pair_t              lead_s  [NSTAGE+1];
    pair_t              trail_s [NSTAGE+1];
    logic [LATENCY-1:0] vpipe;

    // left half-plane: turn both pairs by 180 degrees before iterating
    assign half_turn    = lead_x_in[DATA_W-1];
    assign lead_s[0].x  = widen(lead_x_in, half_turn);
    assign lead_s[0].y  = widen(lead_y_in, half_turn);
    assign trail_s[0].x = widen(trail_x_in, half_turn);
    assign trail_s[0].y = widen(trail_y_in, half_turn);

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        gvr_stage #(
            .FIRST_ITER(s * PER_CLK)
        ) u_stage (
            .clk     (clk),
            .lead_i  (lead_s[s]),
            .trail_i (trail_s[s]),
            .lead_o  (lead_s[s+1]),
            .trail_o (trail_s[s+1])
        );
    end

    gvr_gain u_gain_lead (
        .clk (clk),
        .p_i (lead_s[NSTAGE]),
        .x_o (lead_x_out),
        .y_o (lead_y_out)
    );

    gvr_gain u_gain_trail (
        .clk (clk),
        .p_i (trail_s[NSTAGE]),
        .x_o (trail_x_out),
        .y_o (trail_y_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpipe <= '0;
        end else begin
            vpipe <= {vpipe[LATENCY-2:0], valid_in};
        end
    end

    assign valid_out = vpipe[LATENCY-1];

endmodule

// File: rtl/givens_cordic_pair_chk.sv
module givens_cordic_pair_chk
    import gvr_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    valid_in,
    input logic                    valid_out,
    input logic signed [OUT_W-1:0] lead_x_out,
    input logic signed [OUT_W-1:0] lead_y_out,
    input logic signed [OUT_W-1:0] trail_x_out,
    input logic signed [OUT_W-1:0] trail_y_out
);

    logic [3:0]              seen;
    logic signed [OUT_W:0]   res_abs;
    logic signed [OUT_W:0]   res_bound;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (seen != 4'(LATENCY)) begin
            seen <= seen + 4'd1;
        end
    end

    assign res_abs   = lead_y_out[OUT_W-1] ? -(OUT_W+1)'(lead_y_out) : (OUT_W+1)'(lead_y_out);
    assign res_bound = ((OUT_W+1)'(lead_x_out) >>> 6) + (OUT_W+1)'(2);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (seen < 4'(LATENCY)) |-> !valid_out); // R1

    AST_LATENCY_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 4'(LATENCY)) |-> (valid_out == $past(valid_in, 5))); // R2

    AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> !$isunknown({lead_x_out, lead_y_out, trail_x_out, trail_y_out})); // R3

    AST_LENGTH_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> !lead_x_out[OUT_W-1]); // R4

    AST_RESIDUAL_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (res_abs <= res_bound)); // R5

endmodule

bind givens_cordic_pair givens_cordic_pair_chk u_chk (.*);

// File: tb/givens_cordic_pair_tb.sv
module givens_cordic_pair_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 10;
    localparam int GAP_N      = 7;

    // {lead_x, lead_y, trail_x, trail_y}
    localparam int VEC [NV][4] = '{
        '{ 20000,      0,   1000,   2000},
        '{     0,  15000,   5000,  -3000},
        '{ 12000,   9000,  -7000,   4000},
        '{-20000,   3000,  10000,  10000},
        '{ -9000, -12000,   3000,  -8000},
        '{  8000, -14000, -20000,    500},
        '{ 30000,  30000,  25000, -25000},
        '{-30000,      1, -15000,  12000},
        '{ 10000,    -10,      0,      0},
        '{-32768,      0,  32767, -32768}
    };
    localparam logic [GAP_N-1:0] GAP_PAT = 7'b1001101;

    logic               clk;
    logic               rst_n;
    logic               valid_in;
    logic signed [15:0] lead_x_in, lead_y_in, trail_x_in, trail_y_in;
    logic               valid_out;
    logic signed [16:0] lead_x_out, lead_y_out, trail_x_out, trail_y_out;

    int total = 0;
    int bad   = 0;

    givens_cordic_pair u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_in    (valid_in),
        .lead_x_in   (lead_x_in),
        .lead_y_in   (lead_y_in),
        .trail_x_in  (trail_x_in),
        .trail_y_in  (trail_y_in),
        .valid_out   (valid_out),
        .lead_x_out  (lead_x_out),
        .lead_y_out  (lead_y_out),
        .trail_x_out (trail_x_out),
        .trail_y_out (trail_y_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int lx, input int ly, input int tx, input int ty);
        valid_in   = v;
        lead_x_in  = 16'(lx);
        lead_y_in  = 16'(ly);
        trail_x_in = 16'(tx);
        trail_y_in = 16'(ty);
    endtask

    function automatic real rabs(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    // expected values from the rotation the leading pair actually underwent
    task automatic check_item(input int lx, input int ly, input int tx, input int ty,
                              input string req);
        real lxo, lyo, txo, tyo, mag_in, mag_out, phi, ex, ey;
        lxo = real'(lead_x_out);
        lyo = real'(lead_y_out);
        txo = real'(trail_x_out);
        tyo = real'(trail_y_out);
        check(valid_out == 1'b1, req, "valid_out with result", real'(valid_out), 1.0);
        check(!$isunknown({lead_x_out, lead_y_out, trail_x_out, trail_y_out}), "R3",
              "known outputs", 0.0, 0.0);
        mag_in  = $sqrt(real'(lx) * real'(lx) + real'(ly) * real'(ly));
        mag_out = $sqrt(lxo * lxo + lyo * lyo);
        check(rabs(mag_out - mag_in) <= 4.0, "R4", {req, " lead length"}, mag_out, mag_in);
        check(lxo >= 0.0, "R4", {req, " lead x sign"}, lxo, 0.0);
        check(rabs(lyo) <= real'(int'(lead_x_out) >>> 6) + 2.0, "R5",
              {req, " residual"}, lyo, 0.0);
        phi = $atan2(lyo, lxo) - $atan2(real'(ly), real'(lx));
        ex  = real'(tx) * $cos(phi) - real'(ty) * $sin(phi);
        ey  = real'(tx) * $sin(phi) + real'(ty) * $cos(phi);
        check(rabs(txo - ex) <= 8.0, "R6", {req, " trail x"}, txo, ex);
        check(rabs(tyo - ey) <= 8.0, "R6", {req, " trail y"}, tyo, ey);
    endtask

    task automatic run_one(input int lx, input int ly, input int tx, input int ty,
                           input string req);
        @(negedge clk);
        drive(1'b1, lx, ly, tx, ty);
        @(negedge clk);
        drive(1'b0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        @(negedge clk);
        check_item(lx, ly, tx, ty, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 1000, 2000, 3000, 4000);
        // R1: valid_out stays low during reset even with valid_in high
        repeat (4) begin
            @(negedge clk);
            check(valid_out == 1'b0, "R1", "valid_out in reset", real'(valid_out), 0.0);
        end
        drive(1'b0, 0, 0, 0, 0);
        rst_n = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check(valid_out == 1'b0, "R1", "valid_out after reset", real'(valid_out), 0.0);
        end

        // R3: table streamed back to back, one result per cycle in order
        for (int c = 0; c < NV + 5; c++) begin
            @(negedge clk);
            if (c >= 5) begin
                check_item(VEC[c-5][0], VEC[c-5][1], VEC[c-5][2], VEC[c-5][3],
                           (VEC[c-5][0] < 0) ? "R7 stream" : "R3 stream");
            end
            if (c < NV) drive(1'b1, VEC[c][0], VEC[c][1], VEC[c][2], VEC[c][3]);
            else        drive(1'b0, 0, 0, 0, 0);
        end
        repeat (3) @(negedge clk);

        // R2: single pulse appears exactly five cycles later
        begin
            int n;
            drive(1'b1, 9000, 4000, 100, 200);
            @(negedge clk);
            drive(1'b0, 0, 0, 0, 0);
            n = 1;
            while (!valid_out && n < 20) begin
                @(negedge clk);
                n++;
            end
            check(n == 5, "R2", "latency cycles", real'(n), 5.0);
            @(negedge clk);
            check(valid_out == 1'b0, "R2", "single result cycle", real'(valid_out), 0.0);
        end
        repeat (4) @(negedge clk);

        // R9: gapped valid pattern reproduced five cycles later
        for (int c = 0; c < GAP_N + 5; c++) begin
            @(negedge clk);
            if (c >= 5)
                check(valid_out == GAP_PAT[c-5], "R9", "gapped valid",
                      real'(valid_out), real'(GAP_PAT[c-5]));
            if (c < GAP_N) drive(GAP_PAT[c], 15000, -2000, 700, 800);
            else           drive(1'b0, 0, 0, 0, 0);
        end
        repeat (4) @(negedge clk);

        // R7: leading vector in the third quadrant
        run_one(-16000, -16000, 4000, -6000, "R7 third quadrant");
        // R8: most negative value on both leading coordinates
        run_one(-32768, -32768, 32767, 32767, "R8 full scale");
        check(lead_x_out >= 17'sd46337 && lead_x_out <= 17'sd46345, "R8",
              "full-scale length", real'(lead_x_out), 46341.0);

        // R10: zero leading pair
        @(negedge clk);
        drive(1'b1, 0, 0, 12000, -9000);
        @(negedge clk);
        drive(1'b0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        check(lead_x_out >= -17'sd1 && lead_x_out <= 17'sd1, "R10", "zero lead x",
              real'(lead_x_out), 0.0);
        check(lead_y_out >= -17'sd1 && lead_y_out <= 17'sd1, "R10", "zero lead y",
              real'(lead_y_out), 0.0);
        begin
            real tn;
            tn = $sqrt(real'(trail_x_out) * real'(trail_x_out) +
                       real'(trail_y_out) * real'(trail_y_out));
            check(rabs(tn - 15000.0) <= 6.0, "R10", "trail length kept", tn, 15000.0);
        end

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule